// File: doc/BRIEF.md
# Fixed-Point Rounding Narrower

This block shortens a signed two's-complement sample from a wide working width to a narrower output width. It sits between arithmetic stages of a streaming datapath, such as the butterflies of a transform engine. A fixed number of low-order bits is discarded, and the kept field is adjusted according to a rounding rule. The rule is picked by a parameter when the block is built.

There are four rules: plain truncation, half rounds up, half rounds away from zero, and half rounds to even. The result passes through exactly one register. A one-bit sync flag travels beside the data with the same single-cycle delay, so the flag stays aligned with its sample. A clock enable freezes the stage. The block does not saturate. A positive value that rounds past the top of the output range wraps to the most negative code.

Top module: `rnd_narrow_stage`

## Requirements
- R1: With MODE code 0 (truncate), `dout` equals floor(din / 2^D) taken modulo 2^OUT_W, where D = IN_W - OUT_W.
- R2: With MODE code 1 (half up), `dout` is floor(din / 2^D) plus one whenever discarded bit D-1 is set, taken modulo 2^OUT_W.
- R3: With MODE code 2 (away from zero), an exact half adds one to the floor for a non-negative `din` and leaves the floor unchanged for a negative `din`. An exact half means bit D-1 is set and bits D-2..0 are clear.
- R4: With MODE code 3 (convergent), an exact half goes to whichever of floor and floor+1 has bit 0 clear.
- R5: In modes 2 and 3, a discarded fraction that is not an exact half rounds to the nearest value. A fraction below one half keeps the floor, and a fraction above one half adds one.
- R6: A rising clock edge with `ce` high loads the rounded `din` into `dout` and copies `din_sync` into `dout_sync`, so both have a latency of one cycle.
- R7: A rising clock edge with `ce` low leaves `dout` and `dout_sync` unchanged, whatever `din` and `din_sync` carry.
- R8: While `rst_n` is low, `dout` and `dout_sync` are zero. This takes effect at once, even when a sync pulse is waiting to be loaded.
- R9: Rounding up the largest kept code wraps to the most negative output code, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; the stage holds while it is low |
| din | input | IN_W | Wide signed sample |
| din_sync | input | 1 | Sync flag that accompanies `din` |
| dout | output | OUT_W | Rounded, narrowed signed sample |
| dout_sync | output | 1 | Sync flag delayed to match `dout` |

## Verification
The block has only two state elements: the output word and the delayed flag. Any fault in the increment decision shows on `dout` at the first enabled edge after the input that triggers it. The bench sweeps every input code of a 6-to-3 bit configuration in all four modes, so each fraction class and both signs of exact half are reached.

A stale or badly reset flag register appears as a spurious `dout_sync` pulse in the same cycle as the reset, or one cycle after an enabled edge. A clock-enable fault appears as an output that changes across a disabled edge.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int RND_TRUNC    = 0;
  localparam int RND_HALF_UP  = 1;
  localparam int RND_AWAY     = 2;
  localparam int RND_EVEN     = 3;
endpackage

// File: rtl/rnd_frac_classify.sv
// Classifies the discarded fraction: exactly one half, or strictly above half.
module rnd_frac_classify #(
  parameter int DROP = 4
) (
  input  logic [DROP-1:0] tail,
  output logic            is_half,
  output logic            is_above
);
  generate
    if (DROP == 1) begin : g_single
      assign is_half  = tail[0];
      assign is_above = 1'b0;
    end else begin : g_multi
      logic rest_nz;
      assign rest_nz  = |tail[DROP-2:0];
      assign is_half  = tail[DROP-1] & ~rest_nz;
      assign is_above = tail[DROP-1] &  rest_nz;
    end
  endgenerate
endmodule

// File: rtl/rnd_bump_select.sv
// Decides whether the kept field is incremented, per build-time mode.
module rnd_bump_select
  import rnd_pkg::*;
#(
  parameter int MODE = RND_EVEN
) (
  input  logic is_half,
  input  logic is_above,
  input  logic neg,
  input  logic kept_lsb,
  output logic bump
);
  generate
    if (MODE == RND_TRUNC) begin : g_trunc
      logic unused_inputs;
      assign unused_inputs = ^{is_half, is_above, neg, kept_lsb};
      assign bump = 1'b0;
    end else if (MODE == RND_HALF_UP) begin : g_half_up
      logic unused_inputs;
      assign unused_inputs = ^{neg, kept_lsb};
      assign bump = is_half | is_above;
    end else if (MODE == RND_AWAY) begin : g_away
      logic unused_inputs;
      assign unused_inputs = kept_lsb;
      assign bump = is_above | (is_half & ~neg);
    end else begin : g_even
      logic unused_inputs;
      assign unused_inputs = neg;
      assign bump = is_above | (is_half & kept_lsb);
    end
  endgenerate
endmodule

// File: rtl/rnd_narrow_stage.sv
module rnd_narrow_stage
  import rnd_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter int MODE  = RND_EVEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [IN_W-1:0]  din,
  input  logic             din_sync,
  output logic [OUT_W-1:0] dout,
  output logic             dout_sync
);
  localparam int DROP = IN_W - OUT_W;

  initial assert (OUT_W < IN_W && MODE >= 0 && MODE <= 3);

  logic [OUT_W-1:0] kept;
  logic             is_half, is_above, bump;
  logic [OUT_W:0]   sum_ext;

  assign kept = din[IN_W-1:DROP];

  rnd_frac_classify #(.DROP(DROP)) u_cls (
    .tail    (din[DROP-1:0]),
    .is_half (is_half),
    .is_above(is_above)
  );

  rnd_bump_select #(.MODE(MODE)) u_bump (
    .is_half (is_half),
    .is_above(is_above),
    .neg     (din[IN_W-1]),
    .kept_lsb(kept[0]),
    .bump    (bump)
  );

  // One extra bit so the carry out of the kept field is well defined; it is dropped (wrap).
  assign sum_ext = {kept[OUT_W-1], kept} + {{OUT_W{1'b0}}, bump};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      dout_sync <= 1'b0;
    end else if (ce) begin
      dout      <= sum_ext[OUT_W-1:0];
      dout_sync <= din_sync;
    end
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> dout_sync == $past(din_sync)); // R6
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(dout) && $stable(dout_sync)); // R7
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> OUT_W'(dout - $past(kept)) <= OUT_W'(1)); // R9

  generate
    if (MODE == RND_TRUNC) begin : g_chk_trunc
      AST_TRUNC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> dout == $past(kept)); // R1
    end else if (MODE == RND_HALF_UP) begin : g_chk_up
      AST_HALF_UP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ce && din[DROP-1] |=> dout == OUT_W'($past(kept) + 1'b1)); // R2
    end else if (MODE == RND_AWAY) begin : g_chk_away
      AST_AWAY_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ce && is_half && !din[IN_W-1] |=> dout == OUT_W'($past(kept) + 1'b1)); // R3
      AST_AWAY_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        ce && is_half && din[IN_W-1] |=> dout == $past(kept)); // R3
    end else begin : g_chk_even
      AST_EVEN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        ce && is_half |=> !dout[0]); // R4
      AST_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ce && !din[DROP-1] |=> dout == $past(kept)); // R5
    end
  endgenerate
endmodule

// File: tb/sim_rnd_narrow_stage.sv
`timescale 1ns/1ps
module sim_rnd_narrow_stage;
  localparam int IW = 6;
  localparam int OW = 3;
  localparam int D  = IW - OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [IW-1:0] din = '0;
  logic din_sync = 1'b0;
  logic [OW-1:0] dout_m [4];
  logic          sync_m [4];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    rnd_narrow_stage #(.IN_W(IW), .OUT_W(OW), .MODE(m)) u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .din_sync(din_sync),
      .dout(dout_m[m]), .dout_sync(sync_m[m])
    );
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Unwrapped rounded value, computed arithmetically.
  function automatic int rounded(int mode, int v);
    int fl, fr, half;
    fl = v >>> D;
    fr = v - fl * (1 << D);
    half = 1 << (D - 1);
    case (mode)
      0: return fl;
      1: return fl + ((fr >= half) ? 1 : 0);
      2: return (fr > half) ? fl + 1 : (fr == half) ? ((v >= 0) ? fl + 1 : fl) : fl;
      default: return (fr > half) ? fl + 1 : (fr == half) ? fl + (fl & 1) : fl;
    endcase
  endfunction

  function automatic string tag(int mode, int v);
    int fr;
    fr = v - (v >>> D) * (1 << D);
    if (rounded(mode, v) == (1 << (OW - 1))) return "R9";
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return (fr == (1 << (D - 1))) ? "R3" : "R5";
      default: return (fr == (1 << (D - 1))) ? "R4" : "R5";
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hold_v [4];
    int hold_s [4];
    din = 6'b101010; din_sync = 1'b1; ce = 1'b1;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      check("R8 reset value", int'(dout_m[m]), 0);
      check("R8 reset sync", int'(sync_m[m]), 0);
    end
    rst_n = 1'b1;

    // Exhaustive sweep over all input codes, all modes.
    for (int v = -(1 << (IW - 1)); v < (1 << (IW - 1)); v++) begin
      int s;
      s = ((v % 3) == 0) ? 1 : 0;
      din = IW'(v); din_sync = s[0]; ce = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
        check(tag(m, v), int'(dout_m[m]), rounded(m, v) & ((1 << OW) - 1));
        check("R6 sync latency", int'(sync_m[m]), s);
      end
    end

    // Clock enable low: outputs hold.
    for (int m = 0; m < 4; m++) begin
      hold_v[m] = int'(dout_m[m]);
      hold_s[m] = int'(sync_m[m]);
    end
    ce = 1'b0; din = 6'b011100; din_sync = ~din_sync;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      check("R7 hold value", int'(dout_m[m]), hold_v[m]);
      check("R7 hold sync", int'(sync_m[m]), hold_s[m]);
    end

    // Load a sync pulse, then reset with another one pending.
    ce = 1'b1; din = 6'b010111; din_sync = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) check("R6 sync set", int'(sync_m[m]), 1);
    rst_n = 1'b0;
    #1;
    for (int m = 0; m < 4; m++) begin
      check("R8 reset clears sync", int'(sync_m[m]), 0);
      check("R8 reset clears value", int'(dout_m[m]), 0);
    end
    @(negedge clk);
    for (int m = 0; m < 4; m++) check("R8 sync held low", int'(sync_m[m]), 0);
    rst_n = 1'b1;
    din = 6'b000100; din_sync = 1'b0;
    @(negedge clk);
    check("R3 post-reset half", int'(dout_m[2]), 1);
    check("R4 post-reset half", int'(dout_m[3]), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule